// File: doc/BRIEF.md
# Comparator Edge Flag Register

This block is an 8-bit status and control register that sits beside an analog comparator. It watches the comparator's digital output, which arrives already synchronised to the register clock. It records rising and falling transitions in two separate sticky flags. Software clears a flag by writing a one to its bit. Each flag has its own interrupt enable, and both feed one shared interrupt request line.

Software reaches the register over a plain synchronous bus with a select, a write enable, write data and read data. Read data always shows the current register contents. A module-enable input gates edge detection. While the comparator is disabled, the live-output bit returns the invert-configuration input instead of the comparator output. Edge tracking follows the output while disabled, so turning the module on with a steady output sets no flag.

Top module: `cmp_edge_flag_reg`

## Requirements
- R1: After reset every bit of the read data is zero, given that the comparator output, the enable input and the invert input are held low, and the interrupt request is low.
- R2: Bits 7 to 5 always read zero, and writing ones to them changes no readable bit.
- R3: While enabled, a 0-to-1 change of the comparator output sets the rising flag (bit 2) at the next clock edge, and it stays set.
- R4: While enabled, a 1-to-0 change of the comparator output sets the falling flag (bit 1) at the next clock edge, and it stays set.
- R5: A write with a one in bit 2 or bit 1 clears that flag at the next edge. A zero written to a flag bit leaves that flag as it was.
- R6: When a detected edge and a write-one-clear hit the same flag in the same cycle, the flag ends up set.
- R7: While enabled, bit 0 reads the current comparator output with no register delay. Writes to bit 0 have no effect.
- R8: While disabled, bit 0 reads the invert-configuration input.
- R9: While disabled, no flag sets on any comparator transition. Flags that were already set keep their value.
- R10: Raising the enable input while the comparator output is steady sets neither flag.
- R11: The interrupt request is high exactly when (bit 2 and bit 4 are both set) or (bit 1 and bit 3 are both set).
- R12: The rising enable (bit 4) and the falling enable (bit 3) load from the write data only when select and write enable are both high. Otherwise they hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Address match for this register |
| bus_we | input | 1 | Write strobe, qualified by bus_sel |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Current register contents |
| cmp_out | input | 1 | Synchronised comparator output |
| mod_en | input | 1 | Comparator module enable |
| inv_cfg | input | 1 | Invert configuration, shown on bit 0 while disabled |
| irq | output | 1 | Shared interrupt request |

## Verification
A wrong flag state shows on bus_rdata bits 2 and 1 on the cycle after the edge or write that caused it. It also shows on irq in that same cycle once the matching enable is set, so each scenario samples one cycle after its stimulus. A stale edge-tracking copy shows up only as a spurious or missing flag the cycle after the module is enabled or the output moves. For this reason the bench enables the module with the output held high and reads the flags right away. Set-versus-clear priority is only visible when a transition and a clearing write are driven in the same cycle, and the bench makes that collision on purpose.

// File: rtl/cef_pkg.sv
package cef_pkg;
  localparam int REG_W   = 8;
  localparam int BIT_LIVE = 0;
  localparam int BIT_FF   = 1;
  localparam int BIT_FR   = 2;
  localparam int BIT_IEF  = 3;
  localparam int BIT_IER  = 4;
  localparam int NUM_EDGE = 2;
  localparam int EDGE_RISE = 0;
  localparam int EDGE_FALL = 1;

  typedef struct packed {
    logic ie_rise;
    logic ie_fall;
  } cef_en_t;

  function automatic logic cef_irq(input logic [NUM_EDGE-1:0] flags,
                                   input logic [NUM_EDGE-1:0] ens);
    return |(flags & ens);
  endfunction

  function automatic logic cef_live(input logic en, input logic inv, input logic cmp);
    return en ? cmp : inv;
  endfunction

  function automatic logic [REG_W-1:0] cef_pack(input cef_en_t en,
                                                input logic [NUM_EDGE-1:0] flags,
                                                input logic live);
    logic [REG_W-1:0] v;
    v = '0;
    v[BIT_IER]  = en.ie_rise;
    v[BIT_IEF]  = en.ie_fall;
    v[BIT_FR]   = flags[EDGE_RISE];
    v[BIT_FF]   = flags[EDGE_FALL];
    v[BIT_LIVE] = live;
    return v;
  endfunction
endpackage

// File: rtl/cef_edge_detect.sv
module cef_edge_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic sig_i,
  output logic rise_o,
  output logic fall_o
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sig_i;
  end

  assign rise_o = en_i &  sig_i & ~prev_q;
  assign fall_o = en_i & ~sig_i &  prev_q;

  // R10: enabling with a steady output yields no edge event
  a_r10_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(en_i) && en_i && $stable(sig_i)) |-> (!rise_o && !fall_o));
endmodule

// File: rtl/cef_flag_cell.sv
module cef_flag_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      flag_q <= 1'b0;
    else if (set_i)  flag_q <= 1'b1;
    else if (clr_i)  flag_q <= 1'b0;
  end

  assign flag_o = flag_q;

  // R3 / R6: a set event always leaves the flag high
  a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> flag_o);
  // R5: a clear with no set drops the flag
  a_r5_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !flag_o);
  // R5: no set and no clear keeps the flag
  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !set_i) |=> $stable(flag_o));
endmodule

// File: rtl/cef_bus_if.sv
module cef_bus_if
  import cef_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sel_i,
  input  logic                we_i,
  input  logic [REG_W-1:0]    wdata_i,
  input  logic [NUM_EDGE-1:0] flags_i,
  input  logic                live_i,
  output logic [NUM_EDGE-1:0] clr_o,
  output cef_en_t             en_o,
  output logic [REG_W-1:0]    rdata_o
);
  logic    wr;
  cef_en_t en_q;

  assign wr = sel_i & we_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= '0;
    else if (wr) begin
      en_q.ie_rise <= wdata_i[BIT_IER];
      en_q.ie_fall <= wdata_i[BIT_IEF];
    end
  end

  assign clr_o[EDGE_RISE] = wr & wdata_i[BIT_FR];
  assign clr_o[EDGE_FALL] = wr & wdata_i[BIT_FF];
  assign en_o    = en_q;
  assign rdata_o = cef_pack(en_q, flags_i, live_i);

  // R12: enables only move on a qualified write
  a_r12_en_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable(en_o));
endmodule

// File: rtl/cmp_edge_flag_reg.sv
module cmp_edge_flag_reg
  import cef_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_sel,
  input  logic             bus_we,
  input  logic [REG_W-1:0] bus_wdata,
  output logic [REG_W-1:0] bus_rdata,
  input  logic             cmp_out,
  input  logic             mod_en,
  input  logic             inv_cfg,
  output logic             irq
);
  logic [NUM_EDGE-1:0] edge_evt;
  logic [NUM_EDGE-1:0] flag_clr;
  logic [NUM_EDGE-1:0] flag_q;
  logic                live_bit;
  cef_en_t             en;

  cef_edge_detect u_edge (
    .clk(clk), .rst_n(rst_n), .en_i(mod_en), .sig_i(cmp_out),
    .rise_o(edge_evt[EDGE_RISE]), .fall_o(edge_evt[EDGE_FALL])
  );

  for (genvar g = 0; g < NUM_EDGE; g++) begin : g_flag
    cef_flag_cell u_cell (
      .clk(clk), .rst_n(rst_n), .set_i(edge_evt[g]),
      .clr_i(flag_clr[g]), .flag_o(flag_q[g])
    );
  end

  assign live_bit = cef_live(mod_en, inv_cfg, cmp_out);

  cef_bus_if u_bus (
    .clk(clk), .rst_n(rst_n), .sel_i(bus_sel), .we_i(bus_we),
    .wdata_i(bus_wdata), .flags_i(flag_q), .live_i(live_bit),
    .clr_o(flag_clr), .en_o(en), .rdata_o(bus_rdata)
  );

  assign irq = cef_irq(flag_q, {en.ie_fall, en.ie_rise});

  // R9: while disabled a clear flag stays clear
  a_r9_rise_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!mod_en && !bus_rdata[BIT_FR]) |=> !bus_rdata[BIT_FR]);
  a_r9_fall_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!mod_en && !bus_rdata[BIT_FF]) |=> !bus_rdata[BIT_FF]);
  // R11: no interrupt while all enables are off
  a_r11_no_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_rdata[BIT_IER] && !bus_rdata[BIT_IEF]) |-> !irq);
endmodule

// File: tb/cmp_edge_flag_reg_bench.sv
module cmp_edge_flag_reg_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_sel = 1'b0, bus_we = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       cmp_out = 1'b0, mod_en = 1'b0, inv_cfg = 1'b0;
  logic       irq;
  int         n_run = 0, n_fail = 0;
  bit         done = 1'b0;

  always #2 clk = ~clk;

  cmp_edge_flag_reg u_cmp_edge_flag_reg (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cmp_out(cmp_out),
    .mod_en(mod_en), .inv_cfg(inv_cfg), .irq(irq)
  );

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // one register write, inputs changed at negedge, committed at the posedge
  task automatic wr(input logic [7:0] d);
    @(negedge clk); bus_sel = 1'b1; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk); bus_sel = 1'b0; bus_we = 1'b0; bus_wdata = 8'h00;
  endtask

  task automatic set_cmp(input logic v);
    @(negedge clk); cmp_out = v;
    @(negedge clk);
  endtask

  task automatic t_reset;
    check("R1 rdata", bus_rdata, 8'h00);
    check("R1 irq", {7'b0, irq}, 8'h00);
  endtask

  task automatic t_reserved;
    wr(8'hE0);
    check("R2 reserved write", bus_rdata, 8'h00);
  endtask

  task automatic t_live;
    @(negedge clk); mod_en = 1'b1; inv_cfg = 1'b1; #0.5;
    check("R7 live low", bus_rdata & 8'h01, 8'h00);
    @(negedge clk); cmp_out = 1'b1; #0.5;
    check("R7 live immediate", bus_rdata & 8'h01, 8'h01);
    @(negedge clk);
    check("R3 rise flag", bus_rdata & 8'h06, 8'h04);
    wr(8'h04);
    check("R5 rise cleared", bus_rdata & 8'h06, 8'h00);
    wr(8'h00); // bit0 write ignored
    check("R7 write bit0 ignored", bus_rdata & 8'h01, 8'h01);
    set_cmp(1'b0);
    check("R4 fall flag", bus_rdata & 8'h06, 8'h02);
    wr(8'h04);
    check("R5 zero keeps fall flag", bus_rdata & 8'h06, 8'h02);
    wr(8'h03);
    check("R5 fall cleared", bus_rdata & 8'h07, 8'h00);
  endtask

  task automatic t_disabled;
    @(negedge clk); mod_en = 1'b0; inv_cfg = 1'b1; #0.5;
    check("R8 shows invert", bus_rdata & 8'h01, 8'h01);
    @(negedge clk); inv_cfg = 1'b0; #0.5;
    check("R8 shows invert low", bus_rdata & 8'h01, 8'h00);
    set_cmp(1'b1);
    set_cmp(1'b0);
    set_cmp(1'b1);
    check("R9 no flags when off", bus_rdata & 8'h06, 8'h00);
    // R10: enable with output held high
    @(negedge clk); mod_en = 1'b1;
    @(negedge clk);
    check("R10 no spurious", bus_rdata & 8'h07, 8'h01);
    set_cmp(1'b0);
    @(negedge clk); mod_en = 1'b0;
    set_cmp(1'b1);
    check("R9 held flag kept", bus_rdata & 8'h06, 8'h02);
    @(negedge clk); mod_en = 1'b1;
    wr(8'h02);
    check("R9 cleanup", bus_rdata & 8'h06, 8'h00);
  endtask

  task automatic t_collision;
    // output is 1, enabled; drive fall and clear-fall together
    @(negedge clk); cmp_out = 1'b0; bus_sel = 1'b1; bus_we = 1'b1; bus_wdata = 8'h02;
    @(negedge clk); bus_sel = 1'b0; bus_we = 1'b0; bus_wdata = 8'h00;
    check("R6 set beats clear", bus_rdata & 8'h02, 8'h02);
    wr(8'h02);
    check("R6 later clear", bus_rdata & 8'h02, 8'h00);
  endtask

  task automatic t_irq;
    set_cmp(1'b1);                         // rising flag
    check("R11 masked", {7'b0, irq}, 8'h00);
    wr(8'h10);
    check("R12 rise enable stored", bus_rdata & 8'h18, 8'h10);
    check("R11 rise irq", {7'b0, irq}, 8'h01);
    @(negedge clk); bus_sel = 1'b0; bus_we = 1'b1; bus_wdata = 8'h00;
    @(negedge clk); bus_we = 1'b0;
    check("R12 unselected write ignored", bus_rdata & 8'h18, 8'h10);
    wr(8'h08);
    check("R11 wrong enable", {7'b0, irq}, 8'h00);
    set_cmp(1'b0);
    check("R11 fall irq", {7'b0, irq}, 8'h01);
    wr(8'h0E);
    check("R11 cleared", {7'b0, irq}, 8'h00);
    check("R12 fall enable kept", bus_rdata & 8'h1E, 8'h08);
  endtask

  initial begin
    #1;
    check("R1 in reset", bus_rdata, 8'h00);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_reserved();
    t_live();
    t_disabled();
    set_cmp(1'b1);
    wr(8'h04);
    t_collision();
    t_irq();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule